// File: doc/BRIEF.md
# Dual-Clause MDIO Management Master

This block is a management-bus master that sends serial management frames to external PHY devices over a clock pin (`mdc`) and a bidirectional data pin. The data pin is split into `mdioOut`, `mdioOe` and `mdioIn`, so the pad ring can build the tri-state buffer. Software controls the block through a simple register port. It stores a write value, picks the frame style and clock settings in a configuration register, and starts one frame by writing the command register. When the frame finishes, a pending flag in a data register clears, and for a read the captured 16-bit value appears there.

The meaning of the two-bit command opcode depends on a frame-style bit in the configuration register. In the classic style, a frame carries a PHY address and a register address. In the extended style, the block sends exactly one frame per command. Software reaches an extended register in two steps: it writes the register number into the write-data register and issues an address command, then issues a write or read command to the same PHY and device.

Top module: `mdio_master`

## Requirements
- R1: The register map, decoded on `regAddr`, is as follows. Offsets listed here are in hexadecimal.
  - 0x00 command: register/device address [4:0], PHY address [12:8], opcode [17:16].
  - 0x08 write data: data [15:0], valid bit 16, pending bit 17.
  - 0x10 read data: the same layout as write data.
  - 0x18 configuration: divider [7:0], sample delay [11:8], preamble bit 12, clock idle level bit 13, sample select bit 15, alternate sample delay [20:16], extended style bit 24.
  - 0x20 enable: bit 0.
  - After reset every register reads zero, except the configuration register, which reads 0x00000002.
- R2: While a frame runs, each bit occupies one `mdc` period of 2*max(divider,1) clock cycles, low half first. Between frames, `mdc` sits at the configured idle level.
- R3: A frame is sent MSB first, one bit per `mdc` period, in this order:
  - an optional 32 ones;
  - a 2-bit start code;
  - a 2-bit wire opcode;
  - the 5-bit PHY address;
  - the 5-bit register/device address;
  - a 2-bit turnaround;
  - 16 data bits.
  `mdioOut` changes only while `mdc` is low.
- R4: In the classic style the start code is 01. Opcode 0 is a write, sent on the wire as 01. Opcode 1 is a read, sent as 10. Opcodes 2 and 3 start nothing and set no flag.
- R5: In the extended style the start code is 00, and the wire opcode equals the command opcode:
  - 0 is an address frame;
  - 1 is a write;
  - 2 is a read with address increment;
  - 3 is a read.
  The 32-bit preamble is always sent in this style, whatever bit 12 holds.
- R6: Write and address frames carry turnaround 10 and the write-data value, and drive `mdioOe` high for the whole frame. They set the write pending flag and clear the write valid flag at launch. At the end they clear pending and set valid.
- R7: Read frames release `mdioOe` from the turnaround onward. Each bit is sampled during the high half of `mdc`, after the selected delay (field [11:8], or field [20:16] when bit 15 is set), clamped to the last cycle of that half. At the end, the last 16 sampled bits go to the read-data register, pending clears and valid sets. Read pending sets and read valid clears at launch.
- R8: A command written while either pending flag is set, or while the enable bit is 0, is ignored: no frame starts and the command register keeps its value.
- R9: While the enable bit is 0, any running frame stops, both pending flags clear, `mdioOe` is low, and the configuration returns to the classic style with the preamble bit cleared.
- R10: In the classic style, the preamble bit selects whether the 32 ones are sent, giving a frame of 64 or 32 `mdc` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte offset |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Register read value for `regAddr` (combinational) |
| mdioIn | input | 1 | Data pin value seen from the pad |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data pin drive value |
| mdioOe | output | 1 | Data pin drive enable |

## Verification
The bound checker watches several rules on every cycle:
- the two pending flags are never set together;
- the sequencer is never busy without a pending flag;
- `mdioOe` stays low with no pending frame;
- pending clears after the end-of-frame strobe;
- read valid rises only out of a pending read;
- a command written while pending leaves the command register unchanged;
- disabling forces the classic style.
The serial content of each frame can only be shown by the bench scenarios, which record the pin at each rising `mdc` edge and compare it with a frame built from R3–R5. The same holds for the wire opcode mapping, the period for a given divider, the idle level, and the data returned by a read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_ADDR_W = 6;
  localparam int REG_DATA_W = 32;
  localparam int PHASE_W    = 8;
  localparam int SAMPLE_W   = 4;
  localparam int SHI_W      = 5;
  localparam int ADR_W      = 5;
  localparam int DAT_W      = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 4 + 2 * ADR_W;
  localparam int WORD_BITS  = HDR_BITS + 2 + DAT_W;
  localparam int SHIFT_BITS = PRE_BITS + WORD_BITS;
  localparam int CNT_W      = $clog2(SHIFT_BITS + 1);
  localparam int CMD_W      = 2 + 2 * ADR_W;

  localparam logic [REG_ADDR_W-1:0] OFS_CMD = 6'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_WD  = 6'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_RD  = 6'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_CFG = 6'h18;
  localparam logic [REG_ADDR_W-1:0] OFS_EN  = 6'h20;

  localparam logic [PHASE_W-1:0] PHASE_RESET = 8'd2;

  typedef struct packed {
    logic shiftBit;
    logic captureBit;
    logic frameDone;
  } ctrlStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enabled,
  input  logic               startReq,
  input  logic               longFrame,
  input  logic [PHASE_W-1:0] halfPer,
  input  logic [SHI_W-1:0]   sampleDelay,
  output logic               busy,
  output logic               halfSel,
  output ctrlStrobes_t       strb
);
  localparam logic [CNT_W-1:0] BITS_LONG  = CNT_W'(SHIFT_BITS);
  localparam logic [CNT_W-1:0] BITS_SHORT = CNT_W'(WORD_BITS);

  logic [PHASE_W-1:0] cnt;
  logic [CNT_W-1:0]   bitsLeft;
  logic               armed;
  logic [SHI_W-1:0]   sCnt;
  logic               endHalf;
  logic               lastBit;

  assign endHalf = busy && (cnt == halfPer - 1'b1);
  assign lastBit = (bitsLeft == CNT_W'(1));

  always_comb begin
    strb.captureBit = busy && armed && halfSel && ((sCnt == '0) || endHalf);
    strb.shiftBit   = endHalf && halfSel && !lastBit;
    strb.frameDone  = endHalf && halfSel && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enabled) begin
      busy     <= 1'b0;
      halfSel  <= 1'b0;
      cnt      <= '0;
      bitsLeft <= '0;
      armed    <= 1'b0;
      sCnt     <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy     <= 1'b1;
        halfSel  <= 1'b0;
        cnt      <= '0;
        bitsLeft <= longFrame ? BITS_LONG : BITS_SHORT;
        armed    <= 1'b0;
      end
    end else begin
      cnt <= endHalf ? '0 : cnt + 1'b1;
      if (strb.captureBit) begin
        armed <= 1'b0;
      end else if (armed) begin
        sCnt <= sCnt - 1'b1;
      end
      if (endHalf && !halfSel) begin
        halfSel <= 1'b1;
        armed   <= 1'b1;
        sCnt    <= sampleDelay;
      end
      if (endHalf && halfSel) begin
        halfSel <= 1'b0;
        if (lastBit) busy <= 1'b0;
        else bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic [REG_DATA_W-1:0] regWrData,
  output logic [REG_DATA_W-1:0] regRdData,
  input  logic                  mdioIn,
  input  ctrlStrobes_t          strb,
  input  logic                  busy,
  output logic                  startReq,
  output logic                  longFrame,
  output logic [PHASE_W-1:0]    halfPer,
  output logic [SHI_W-1:0]      sampleDelay,
  output logic                  enBit,
  output logic                  cfgIdle,
  output logic                  cfgC45,
  output logic                  wrPend,
  output logic                  rdPend,
  output logic                  rdVal,
  output logic [CMD_W-1:0]      cmdWord,
  output logic                  mdioOut,
  output logic                  mdioOe
);
  logic [ADR_W-1:0]    cmdPhy, cmdRga;
  logic [1:0]          cmdOp;
  logic [DAT_W-1:0]    wrData, rdData, rdShift, rdNext;
  logic                wrVal;
  logic [PHASE_W-1:0]  cfgPhase;
  logic [SAMPLE_W-1:0] cfgSample;
  logic [SHI_W-1:0]    cfgShi;
  logic                cfgPre, cfgSmode;
  logic [SHIFT_BITS-1:0] frameReg, oeReg;
  logic                curRead;

  logic                cmdWr, isRead, opLegal;
  logic [1:0]          opIn, wireOp, startCode;
  logic [WORD_BITS-1:0] word, oeWord;
  logic                unusedWrBits;

  assign unusedWrBits = &{regWrData[31:25], regWrData[23:21], regWrData[14]};

  assign cmdWr     = regWr && (regAddr == OFS_CMD);
  assign opIn      = regWrData[17:16];
  assign isRead    = cfgC45 ? opIn[1] : (opIn == 2'd1);
  assign opLegal   = cfgC45 || !opIn[1];
  assign wireOp    = cfgC45 ? opIn : ((opIn == 2'd0) ? 2'b01 : 2'b10);
  assign startCode = cfgC45 ? 2'b00 : 2'b01;
  assign word      = {startCode, wireOp, regWrData[12:8], regWrData[4:0],
                      isRead ? 2'b11 : 2'b10,
                      isRead ? {DAT_W{1'b1}} : wrData};
  assign oeWord    = isRead ? {{HDR_BITS{1'b1}}, {(WORD_BITS - HDR_BITS){1'b0}}}
                            : {WORD_BITS{1'b1}};
  assign startReq  = cmdWr && enBit && !wrPend && !rdPend && opLegal;
  assign longFrame = cfgPre || cfgC45;
  assign halfPer   = (cfgPhase == '0) ? PHASE_W'(1) : cfgPhase;
  assign sampleDelay = cfgSmode ? cfgShi : SHI_W'(cfgSample);
  assign rdNext    = {rdShift[DAT_W-2:0], mdioIn};
  assign cmdWord   = {cmdOp, cmdPhy, cmdRga};
  assign mdioOut   = frameReg[SHIFT_BITS-1];
  assign mdioOe    = oeReg[SHIFT_BITS-1] && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPhy <= '0; cmdRga <= '0; cmdOp <= '0;
      wrData <= '0; wrVal <= 1'b0; wrPend <= 1'b0;
      rdData <= '0; rdVal <= 1'b0; rdPend <= 1'b0;
      cfgPhase <= PHASE_RESET; cfgSample <= '0; cfgShi <= '0;
      cfgPre <= 1'b0; cfgIdle <= 1'b0; cfgSmode <= 1'b0; cfgC45 <= 1'b0;
      enBit <= 1'b0;
      frameReg <= '0; oeReg <= '0; rdShift <= '0; curRead <= 1'b0;
    end else begin
      if (regWr && regAddr == OFS_WD) wrData <= regWrData[DAT_W-1:0];
      if (regWr && regAddr == OFS_EN) enBit <= regWrData[0];
      if (regWr && regAddr == OFS_CFG) begin
        cfgPhase  <= regWrData[7:0];
        cfgSample <= regWrData[11:8];
        cfgPre    <= regWrData[12];
        cfgIdle   <= regWrData[13];
        cfgSmode  <= regWrData[15];
        cfgShi    <= regWrData[20:16];
        cfgC45    <= regWrData[24];
      end
      if (startReq) begin
        cmdRga   <= regWrData[4:0];
        cmdPhy   <= regWrData[12:8];
        cmdOp    <= opIn;
        curRead  <= isRead;
        frameReg <= longFrame ? {{PRE_BITS{1'b1}}, word} : {word, {PRE_BITS{1'b0}}};
        oeReg    <= longFrame ? {{PRE_BITS{1'b1}}, oeWord} : {oeWord, {PRE_BITS{1'b0}}};
        if (isRead) begin
          rdPend <= 1'b1; rdVal <= 1'b0;
        end else begin
          wrPend <= 1'b1; wrVal <= 1'b0;
        end
      end
      if (strb.shiftBit) begin
        frameReg <= frameReg << 1;
        oeReg    <= oeReg << 1;
      end
      if (strb.captureBit) rdShift <= rdNext;
      if (strb.frameDone) begin
        if (curRead) begin
          rdPend <= 1'b0;
          rdVal  <= 1'b1;
          rdData <= strb.captureBit ? rdNext : rdShift;
        end else begin
          wrPend <= 1'b0;
          wrVal  <= 1'b1;
        end
      end
      if (!enBit) begin
        wrPend <= 1'b0;
        rdPend <= 1'b0;
        cfgC45 <= 1'b0;
        cfgPre <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CMD: regRdData = {14'b0, cmdOp, 3'b0, cmdPhy, 3'b0, cmdRga};
      OFS_WD:  regRdData = {14'b0, wrPend, wrVal, wrData};
      OFS_RD:  regRdData = {14'b0, rdPend, rdVal, rdData};
      OFS_CFG: regRdData = {7'b0, cfgC45, 3'b0, cfgShi, cfgSmode, 1'b0,
                            cfgIdle, cfgPre, cfgSample, cfgPhase};
      OFS_EN:  regRdData = {31'b0, enBit};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  regAddr,
  input  logic        regWr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe
);
  ctrlStrobes_t       strb;
  logic               busy, halfSel, startReq, longFrame;
  logic [PHASE_W-1:0] halfPer;
  logic [SHI_W-1:0]   sampleDelay;
  logic               enBit, cfgIdle, cfgC45, wrPend, rdPend, rdVal;
  logic [CMD_W-1:0]   cmdWord;

  assign mdc = busy ? halfSel : cfgIdle;

  mdio_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enabled(enBit), .startReq(startReq),
    .longFrame(longFrame), .halfPer(halfPer), .sampleDelay(sampleDelay),
    .busy(busy), .halfSel(halfSel), .strb(strb)
  );

  mdio_datapath dp_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .mdioIn(mdioIn),
    .strb(strb), .busy(busy), .startReq(startReq), .longFrame(longFrame),
    .halfPer(halfPer), .sampleDelay(sampleDelay), .enBit(enBit),
    .cfgIdle(cfgIdle), .cfgC45(cfgC45), .wrPend(wrPend), .rdPend(rdPend),
    .rdVal(rdVal), .cmdWord(cmdWord), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             mdioOe,
  input logic             busy,
  input logic             wrPend,
  input logic             rdPend,
  input logic             rdVal,
  input logic             enBit,
  input logic             cfgC45,
  input logic             cmdWr,
  input logic [CMD_W-1:0] cmdWord,
  input ctrlStrobes_t     strb
);
  assert_one_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({wrPend, rdPend}) <= 1);
  assert_busy_has_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (wrPend || rdPend));
  assert_no_drive_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPend || rdPend) |-> !mdioOe);
  assert_done_clears_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> !(wrPend || rdPend));
  assert_valid_from_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdVal) |-> $past(rdPend));
  assert_cmd_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && (wrPend || rdPend)) |=> $stable(cmdWord));
  assert_disable_classic_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> !cfgC45);
endmodule

bind mdio_master mdio_master_checker chk_i (
  .clk(clk), .rstN(rstN), .mdioOe(mdioOe), .busy(busy), .wrPend(wrPend),
  .rdPend(rdPend), .rdVal(rdVal), .enBit(enBit), .cfgC45(cfgC45),
  .cmdWr(regWr && (regAddr == 6'h00)), .cmdWord(cmdWord), .strb(strb)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdioIn = 1'b0;
  logic        mdc, mdioOut, mdioOe;

  int nChk = 0, nFail = 0;
  bit summaryDone = 0;
  logic [63:0] seenOut = '0, seenOe = '0;
  int seenN = 0;
  int expBits = 0;
  logic [15:0] pat = '0;

  always #2 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  always @(posedge mdc) begin
    seenOut = {seenOut[62:0], mdioOut};
    seenOe  = {seenOe[62:0], mdioOe};
    seenN   = seenN + 1;
  end

  always @(negedge mdc) begin
    if (seenN >= expBits - 16 && seenN < expBits)
      mdioIn = pat[15 - (seenN - (expBits - 16))];
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  function automatic logic [31:0] cfgVal(input logic [7:0] ph, input logic [3:0] smp,
      input logic pre, input logic idle, input logic smode, input logic [4:0] shi,
      input logic c45);
    return {7'b0, c45, 3'b0, shi, smode, 1'b0, idle, pre, smp, ph};
  endfunction

  function automatic logic [31:0] cmdVal(input logic [1:0] op, input logic [4:0] phy,
      input logic [4:0] rga);
    return {14'b0, op, 3'b0, phy, 3'b0, rga};
  endfunction

  function automatic logic [31:0] frm(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rga, input logic [1:0] ta,
      input logic [15:0] d);
    return {st, op, phy, rga, ta, d};
  endfunction

  task automatic waitIdle();
    logic [31:0] w, r;
    for (int i = 0; i < 4000; i++) begin
      rdReg(6'h08, w);
      rdReg(6'h10, r);
      if (!w[17] && !r[17]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic startFrame(input int bits);
    @(negedge clk);
    seenN = 0; seenOut = '0; seenOe = '0; expBits = bits;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(6'h00, v); check("R1 cmd reset", v, 0);
    rdReg(6'h08, v); check("R1 wdata reset", v, 0);
    rdReg(6'h10, v); check("R1 rdata reset", v, 0);
    rdReg(6'h18, v); check("R1 cfg reset", v, 32'h2);
    rdReg(6'h20, v); check("R1 enable reset", v, 0);
    check("R2 mdc idle low", mdc, 0);
    check("R9 oe low", mdioOe, 0);
  endtask

  task automatic testC22Write();
    logic [31:0] v;
    wrReg(6'h18, cfgVal(8'd2, 4'd0, 0, 0, 0, 5'd0, 0));
    wrReg(6'h08, 32'h0000_A5C3);
    startFrame(32);
    wrReg(6'h00, cmdVal(2'd0, 5'h13, 5'h0B));
    repeat (6) @(negedge clk);
    rdReg(6'h08, v); check("R6 write pending during frame", v[17:16], 2'b10);
    waitIdle();
    check("R10 short frame length", seenN, 32);
    check("R4 c22 write bits", seenOut[31:0], frm(2'b01, 2'b01, 5'h13, 5'h0B, 2'b10, 16'hA5C3));
    check("R6 oe whole write", seenOe[31:0], 32'hFFFF_FFFF);
    rdReg(6'h08, v); check("R6 write done flags", v, 32'h0001_A5C3);
    rdReg(6'h00, v); check("R1 cmd readback", v, cmdVal(2'd0, 5'h13, 5'h0B));
  endtask

  task automatic testC22Read();
    logic [31:0] v;
    wrReg(6'h18, cfgVal(8'd3, 4'd1, 1, 0, 0, 5'd0, 0));
    pat = 16'h3C5A;
    startFrame(64);
    wrReg(6'h00, cmdVal(2'd1, 5'h07, 5'h1E));
    repeat (6) @(negedge clk);
    rdReg(6'h10, v); check("R7 read pending during frame", v[17:16], 2'b10);
    waitIdle();
    check("R10 long frame length", seenN, 64);
    check("R3 preamble ones", seenOut[63:32], 32'hFFFF_FFFF);
    check("R4 c22 read header", seenOut[31:18], {2'b01, 2'b10, 5'h07, 5'h1E});
    check("R7 oe released at turnaround", seenOe, {46'h3FFF_FFFF_FFFF, 18'h0});
    rdReg(6'h10, v); check("R7 read data", v, 32'h0001_3C5A);
  endtask

  task automatic testIllegalOp();
    logic [31:0] v;
    startFrame(32);
    wrReg(6'h00, cmdVal(2'd2, 5'h01, 5'h01));
    repeat (40) @(negedge clk);
    check("R4 opcode 2 no frame", seenN, 0);
    rdReg(6'h10, v); check("R4 opcode 2 no pending", v[17], 0);
    rdReg(6'h08, v); check("R4 opcode 2 no write pending", v[17], 0);
    rdReg(6'h00, v); check("R4 opcode 2 cmd kept", v, cmdVal(2'd1, 5'h07, 5'h1E));
  endtask

  task automatic testPendingIgnore();
    logic [31:0] v;
    wrReg(6'h18, cfgVal(8'd2, 4'd0, 0, 0, 0, 5'd0, 0));
    wrReg(6'h08, 32'h0000_0F0F);
    startFrame(32);
    wrReg(6'h00, cmdVal(2'd0, 5'h01, 5'h02));
    wrReg(6'h00, cmdVal(2'd1, 5'h1F, 5'h1F));
    rdReg(6'h00, v); check("R8 cmd held while pending", v, cmdVal(2'd0, 5'h01, 5'h02));
    waitIdle();
    check("R8 one frame only", seenN, 32);
    check("R8 first frame sent", seenOut[31:0], frm(2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'h0F0F));
    rdReg(6'h10, v); check("R8 no read started", v[17], 0);
  endtask

  task automatic testC45Addr();
    logic [31:0] v;
    wrReg(6'h18, cfgVal(8'd2, 4'd0, 0, 0, 0, 5'd0, 1));
    wrReg(6'h08, 32'h0000_1234);
    startFrame(64);
    wrReg(6'h00, cmdVal(2'd0, 5'h03, 5'h01));
    waitIdle();
    check("R5 forced preamble length", seenN, 64);
    check("R5 forced preamble ones", seenOut[63:32], 32'hFFFF_FFFF);
    check("R5 address frame", seenOut[31:0], frm(2'b00, 2'b00, 5'h03, 5'h01, 2'b10, 16'h1234));
    rdReg(6'h18, v); check("R5 mode bit readback", v[24], 1);
  endtask

  task automatic testC45Read(input logic [1:0] op, input logic [31:0] cfg, input logic [15:0] p);
    logic [31:0] v;
    wrReg(6'h18, cfg);
    pat = p;
    startFrame(64);
    wrReg(6'h00, cmdVal(op, 5'h0A, 5'h04));
    waitIdle();
    check("R5 c45 read header", seenOut[31:18], {2'b00, op, 5'h0A, 5'h04});
    rdReg(6'h10, v); check("R7 c45 read data", v, {14'b0, 2'b01, p});
  endtask

  task automatic testDivider(input logic [7:0] ph, input int expPer);
    time t1, t2;
    wrReg(6'h18, cfgVal(ph, 4'd0, 0, 0, 0, 5'd0, 0));
    startFrame(32);
    wrReg(6'h00, cmdVal(2'd0, 5'h00, 5'h00));
    @(posedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check("R2 mdc period", (t2 - t1) / 4, expPer);
    waitIdle();
  endtask

  task automatic testIdleHigh();
    wrReg(6'h18, cfgVal(8'd2, 4'd0, 0, 1, 0, 5'd0, 0));
    @(negedge clk);
    check("R2 idle high before", mdc, 1);
    startFrame(32);
    wrReg(6'h00, cmdVal(2'd0, 5'h05, 5'h05));
    waitIdle();
    check("R2 idle high frame bits", seenN, 32);
    check("R2 idle high after", mdc, 1);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    wrReg(6'h18, cfgVal(8'd2, 4'd0, 1, 0, 0, 5'd0, 1));
    pat = 16'hFFFF;
    startFrame(64);
    wrReg(6'h00, cmdVal(2'd3, 5'h02, 5'h02));
    repeat (40) @(negedge clk);
    wrReg(6'h20, 32'h0);
    repeat (2) @(negedge clk);
    rdReg(6'h10, v); check("R9 pending cleared", v[17], 0);
    rdReg(6'h18, v); check("R9 classic style restored", {v[24], v[12]}, 2'b00);
    check("R9 oe low when disabled", mdioOe, 0);
    startFrame(32);
    wrReg(6'h00, cmdVal(2'd0, 5'h09, 5'h09));
    repeat (30) @(negedge clk);
    check("R8 no frame while disabled", seenN, 0);
    rdReg(6'h00, v); check("R8 cmd kept while disabled", v, cmdVal(2'd3, 5'h02, 5'h02));
    wrReg(6'h20, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    wrReg(6'h20, 32'h1);
    testC22Write();
    testC22Read();
    testIllegalOp();
    testPendingIgnore();
    testC45Addr();
    testC45Read(2'd3, cfgVal(8'd2, 4'd0, 0, 0, 0, 5'd0, 1), 16'hBEEF);
    testC45Read(2'd2, cfgVal(8'd4, 4'd2, 0, 0, 1, 5'd31, 1), 16'h8421);
    testDivider(8'd0, 2);
    testDivider(8'd5, 10);
    testIdleHigh();
    testDisable();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    end
    $finish;
  end

  initial begin
    #700000;
    if (!summaryDone) begin
      summaryDone = 1;
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    end
    $finish;
  end
endmodule